// File: doc/BRIEF.md
# Daily Tick Counter with Midnight Rollover

This block keeps the time of day as a count of system-timer ticks, about 18.2 per second. Each tick pulse from the timer advances a 32-bit count by one. When the count reaches one full day of ticks, it returns to zero and a rollover byte records that midnight has passed. The host reads the count and the rollover byte with a single read command, and that read clears the rollover byte. The host can also write a new count, or preset the count from packed-BCD hours, minutes and seconds taken from a real-time clock.

Each tick the block accepts is echoed on a one-cycle strobe. Downstream logic uses that strobe in place of a software callback on every tick.

Top module: `tod_tick_counter`

## Requirements
- R1: Each cycle with `tick_in` high and no load or preset increments the count by exactly 1.
- R2: If the incremented count would be greater than or equal to DAY_TICKS (default 0x001800B0), the count becomes 0 and the rollover byte increments. This also applies to a loaded count that is already above the threshold.
- R3: The rollover byte saturates at 0xFF. Further wraps leave it at 0xFF.
- R4: When `rd_req` is high at a clock edge, `rd_hi`/`rd_lo` (count bits 31:16 / 15:0) and `rd_roll` take the values held before that edge. `rd_valid` is high for exactly the following cycle.
- R5: A read clears the rollover byte. If a wrap happens in the same cycle as the read, the rollover byte afterwards is 1.
- R6: `ld_req` sets the count to {`ld_hi`,`ld_lo`} and clears the rollover byte. It wins over `preset_req` in the same cycle.
- R7: A tick in the same cycle as a load or preset is ignored. It does not advance the loaded count and does not pulse `tick_out`.
- R8: `preset_req` sets the count to s*18206507/1000000 + m*10923904/10000 + h*65543427/1000, each term truncated integer division, and clears the rollover byte.
- R9: Each BCD input byte is decoded as its bits 3:0 plus ten times its bits 7:4.
- R10: `tick_out` is high for exactly one cycle, in the cycle after each accepted tick.
- R11: After reset the count, rollover byte, read outputs, `rd_valid` and `tick_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Timer tick pulse, one cycle per tick |
| rd_req | input | 1 | Read the count and rollover byte; clears the rollover byte |
| ld_req | input | 1 | Load the count from `ld_hi`/`ld_lo` |
| ld_hi | input | 16 | Upper half of the load value |
| ld_lo | input | 16 | Lower half of the load value |
| preset_req | input | 1 | Load the count computed from the BCD time inputs |
| bcd_hour | input | 8 | Packed-BCD hours |
| bcd_min | input | 8 | Packed-BCD minutes |
| bcd_sec | input | 8 | Packed-BCD seconds |
| rd_hi | output | 16 | Count bits 31:16 captured by the last read |
| rd_lo | output | 16 | Count bits 15:0 captured by the last read |
| rd_roll | output | 8 | Rollover byte captured by the last read |
| rd_valid | output | 1 | High for the cycle after a read |
| tick_out | output | 1 | One-cycle strobe after each accepted tick |

## Verification
Single ticks from small counts are read back to separate a correct +1 step from a skipped or doubled step. Loads placed just below the threshold, exactly one under it, and at 0xFFFFFFFF probe the wrap comparison for off-by-one errors and for overflow of the sum. A read issued on the same edge as a wrapping tick separates "clear, then add the wrap" from simply losing the wrap. A second instance with a four-tick day runs ticks back to back until the rollover byte would pass 0xFF, which shows saturation rather than wraparound. Presets at 00:00:00, 12:34:56 and 23:59:59 catch BCD nibble mistakes and errors in the per-term truncation; ticks and presets on the same edge check that the load wins.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ROLL_W = 8;
  localparam logic [CNT_W-1:0] DAY_TICKS_DEF = 32'h0018_00B0;

  // packed BCD byte to binary: ones nibble plus tens nibble * 10
  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return 8'(b[3:0]) + 8'(b[7:4]) * 8'd10;
  endfunction

  // ticks elapsed since midnight for a BCD time of day
  function automatic logic [CNT_W-1:0] tod_to_ticks(input logic [7:0] h_bcd,
                                                    input logic [7:0] m_bcd,
                                                    input logic [7:0] s_bcd);
    logic [63:0] hs, ms, ss;
    ss = (64'(bcd_to_bin(s_bcd)) * 64'd18206507) / 64'd1000000;
    ms = (64'(bcd_to_bin(m_bcd)) * 64'd10923904) / 64'd10000;
    hs = (64'(bcd_to_bin(h_bcd)) * 64'd65543427) / 64'd1000;
    return CNT_W'(ss + ms + hs);
  endfunction
endpackage

// File: rtl/tod_preset_calc.sv
module tod_preset_calc
  import tod_pkg::*;
(
  input  logic [7:0]       bcd_hour,
  input  logic [7:0]       bcd_min,
  input  logic [7:0]       bcd_sec,
  output logic [CNT_W-1:0] preset_val
);
  always_comb preset_val = tod_to_ticks(bcd_hour, bcd_min, bcd_sec);
endmodule

// File: rtl/tod_count_core.sv
module tod_count_core
  import tod_pkg::*;
#(
  parameter logic [CNT_W-1:0] DAY_TICKS = DAY_TICKS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              ld_en,
  input  logic [CNT_W-1:0]  ld_val,
  input  logic              rd_clr,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ROLL_W-1:0] roll_q,
  output logic              tick_step,
  output logic              wrap_ev,
  output logic              tick_out
);
  localparam logic [ROLL_W-1:0] ROLL_MAX = '1;

  logic [CNT_W:0]      cnt_inc;
  logic [ROLL_W-1:0]   roll_base;

  always_comb begin
    tick_step = tick_in & ~ld_en;
    cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap_ev   = tick_step & (cnt_inc >= {1'b0, DAY_TICKS});
    roll_base = rd_clr ? '0 : roll_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      roll_q   <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= tick_step;
      if (ld_en) begin
        cnt_q  <= ld_val;
        roll_q <= '0;
      end else begin
        if (wrap_ev) begin
          cnt_q  <= '0;
          roll_q <= (roll_base == ROLL_MAX) ? ROLL_MAX : roll_base + 1'b1;
        end else begin
          if (tick_step) cnt_q <= cnt_inc[CNT_W-1:0];
          roll_q <= roll_base;
        end
      end
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_step && !wrap_ev) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (cnt_q == '0 && roll_q != '0)); // R2
  AST_ROLL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_q == ROLL_MAX && !rd_clr && !ld_en) |=> (roll_q == ROLL_MAX)); // R3
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wrap_ev) |=> (roll_q == '0)); // R5
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt_q == $past(ld_val) && roll_q == '0)); // R6
  AST_LOAD_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !tick_out); // R7
  AST_TICK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in && !ld_en) |=> tick_out); // R10
endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ROLL_W-1:0] roll_q,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [ROLL_W-1:0] rd_roll,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      rd_roll  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_cnt  <= cnt_q;
        rd_roll <= roll_q;
      end
    end
  end

  AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && rd_cnt == $past(cnt_q) && rd_roll == $past(roll_q))); // R4
endmodule

// File: rtl/tod_tick_counter.sv
module tod_tick_counter
  import tod_pkg::*;
#(
  parameter logic [CNT_W-1:0] DAY_TICKS = DAY_TICKS_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic        rd_req,
  input  logic        ld_req,
  input  logic [15:0] ld_hi,
  input  logic [15:0] ld_lo,
  input  logic        preset_req,
  input  logic [7:0]  bcd_hour,
  input  logic [7:0]  bcd_min,
  input  logic [7:0]  bcd_sec,
  output logic [15:0] rd_hi,
  output logic [15:0] rd_lo,
  output logic [7:0]  rd_roll,
  output logic        rd_valid,
  output logic        tick_out
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  preset_val, ld_val, cnt_q, rd_cnt;
  logic [ROLL_W-1:0] roll_q;
  logic              ld_en, tick_step, wrap_ev;

  // explicit load outranks preset
  always_comb begin
    ld_en  = ld_req | preset_req;
    ld_val = ld_req ? {ld_hi, ld_lo} : preset_val;
  end

  tod_preset_calc u_preset (
    .bcd_hour(bcd_hour), .bcd_min(bcd_min), .bcd_sec(bcd_sec),
    .preset_val(preset_val)
  );

  tod_count_core #(.DAY_TICKS(DAY_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ld_en(ld_en),
    .ld_val(ld_val), .rd_clr(rd_req), .cnt_q(cnt_q), .roll_q(roll_q),
    .tick_step(tick_step), .wrap_ev(wrap_ev), .tick_out(tick_out)
  );

  tod_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cnt_q(cnt_q),
    .roll_q(roll_q), .rd_cnt(rd_cnt), .rd_roll(rd_roll), .rd_valid(rd_valid)
  );

  always_comb begin
    rd_hi = rd_cnt[CNT_W-1:HALF_W];
    rd_lo = rd_cnt[HALF_W-1:0];
  end

  AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_req && !ld_req) |=> (cnt_q == $past(tod_to_ticks(bcd_hour, bcd_min, bcd_sec)))); // R8
  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_out && !tick_step) |=> !tick_out); // R10
endmodule

// File: tb/tod_tick_counter_bench.sv
module tod_tick_counter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 0, rd_req = 0, ld_req = 0, preset_req = 0;
  logic [15:0] ld_hi = 0, ld_lo = 0;
  logic [7:0] bcd_hour = 0, bcd_min = 0, bcd_sec = 0;
  logic [15:0] rd_hi, rd_lo;
  logic [7:0] rd_roll;
  logic rd_valid, tick_out;
  // small-day instance for saturation
  logic s_tick = 0, s_rd = 0;
  logic [15:0] s_hi, s_lo;
  logic [7:0] s_roll;
  logic s_valid, s_tout;

  int n_run = 0, n_fail = 0;
  localparam logic [31:0] DAY = 32'h0018_00B0;

  always #2.5 clk = ~clk;

  tod_tick_counter u_tod_tick_counter (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .rd_req(rd_req), .ld_req(ld_req),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .preset_req(preset_req), .bcd_hour(bcd_hour),
    .bcd_min(bcd_min), .bcd_sec(bcd_sec), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_roll(rd_roll), .rd_valid(rd_valid), .tick_out(tick_out));

  tod_tick_counter #(.DAY_TICKS(32'd4)) u_small (
    .clk(clk), .rst_n(rst_n), .tick_in(s_tick), .rd_req(s_rd), .ld_req(1'b0),
    .ld_hi(16'h0), .ld_lo(16'h0), .preset_req(1'b0), .bcd_hour(8'h0),
    .bcd_min(8'h0), .bcd_sec(8'h0), .rd_hi(s_hi), .rd_lo(s_lo),
    .rd_roll(s_roll), .rd_valid(s_valid), .tick_out(s_tout));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk); ld_req = 1; {ld_hi, ld_lo} = v;
    @(negedge clk); ld_req = 0;
  endtask

  task automatic tick1();
    @(negedge clk); tick_in = 1;
    @(negedge clk); tick_in = 0;
  endtask

  // read: values valid at the negedge after the capturing edge
  task automatic do_read(output logic [31:0] c, output logic [7:0] r);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    c = {rd_hi, rd_lo}; r = rd_roll;
  endtask

  function automatic int dec(input logic [7:0] b);
    return int'(b >> 4) * 10 + int'(b & 8'h0F);
  endfunction

  function automatic logic [31:0] tod_ref(input logic [7:0] h, m, s);
    longint t;
    t = longint'(dec(s)) * 18206507 / 1000000;
    t += longint'(dec(m)) * 10923904 / 10000;
    t += longint'(dec(h)) * 65543427 / 1000;
    return t[31:0];
  endfunction

  task automatic t_reset();
    check("R11", "rd_hi", {16'h0, rd_hi}, 0);
    check("R11", "rd_lo", {16'h0, rd_lo}, 0);
    check("R11", "rd_roll", {24'h0, rd_roll}, 0);
    check("R11", "rd_valid", {31'h0, rd_valid}, 0);
    check("R11", "tick_out", {31'h0, tick_out}, 0);
  endtask

  task automatic t_ticks();
    logic [31:0] c; logic [7:0] r;
    do_read(c, r);
    check("R11", "count after reset", c, 0);
    tick1();
    check("R10", "tick_out after tick", {31'h0, tick_out}, 1);
    @(negedge clk);
    check("R10", "tick_out one cycle", {31'h0, tick_out}, 0);
    tick1(); tick1();
    do_read(c, r);
    check("R1", "count after 3 ticks", c, 3);
    load(32'h0001_FFFF);
    tick1();
    do_read(c, r);
    check("R1", "carry across halves", c, 32'h0002_0000);
  endtask

  task automatic t_read_valid();
    logic [31:0] c; logic [7:0] r;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    check("R4", "rd_valid after read", {31'h0, rd_valid}, 1);
    @(negedge clk);
    check("R4", "rd_valid one cycle", {31'h0, rd_valid}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] c; logic [7:0] r;
    load(DAY - 2);
    tick1();
    do_read(c, r);
    check("R2", "no wrap below threshold", c, DAY - 1);
    check("R2", "roll before wrap", {24'h0, r}, 0);
    tick1();
    do_read(c, r);
    check("R2", "wrap to zero", c, 0);
    check("R2", "roll after wrap", {24'h0, r}, 1);
    do_read(c, r);
    check("R5", "roll cleared by read", {24'h0, r}, 0);
    load(32'hFFFF_FFFF);
    tick1();
    do_read(c, r);
    check("R2", "wrap from above threshold", c, 0);
    check("R2", "roll from above threshold", {24'h0, r}, 1);
  endtask

  task automatic t_read_with_wrap();
    logic [31:0] c; logic [7:0] r;
    load(DAY - 1);
    @(negedge clk); rd_req = 1; tick_in = 1;
    @(negedge clk); rd_req = 0; tick_in = 0;
    check("R4", "read shows pre-tick count", {rd_hi, rd_lo}, DAY - 1);
    check("R4", "read shows pre-wrap roll", {24'h0, rd_roll}, 0);
    do_read(c, r);
    check("R5", "wrap kept after clearing read", {24'h0, r}, 1);
    check("R5", "count zero", c, 0);
  endtask

  task automatic t_load_priority();
    logic [31:0] c; logic [7:0] r;
    load(DAY - 1);
    tick1();                          // roll becomes 1
    @(negedge clk); ld_req = 1; {ld_hi, ld_lo} = 32'h0000_1234; tick_in = 1;
    @(negedge clk); ld_req = 0; tick_in = 0;
    check("R7", "tick_out suppressed by load", {31'h0, tick_out}, 0);
    do_read(c, r);
    check("R7", "tick ignored under load", c, 32'h1234);
    check("R6", "load clears roll", {24'h0, r}, 0);
    bcd_hour = 8'h12; bcd_min = 8'h34; bcd_sec = 8'h56;
    @(negedge clk); ld_req = 1; preset_req = 1; {ld_hi, ld_lo} = 32'h0000_0777;
    @(negedge clk); ld_req = 0; preset_req = 0;
    do_read(c, r);
    check("R6", "load beats preset", c, 32'h777);
  endtask

  task automatic t_preset(input logic [7:0] h, m, s, input logic with_tick);
    logic [31:0] c; logic [7:0] r;
    load(DAY - 1);
    tick1();                          // roll becomes 1
    bcd_hour = h; bcd_min = m; bcd_sec = s;
    @(negedge clk); preset_req = 1; tick_in = with_tick;
    @(negedge clk); preset_req = 0; tick_in = 0;
    do_read(c, r);
    check("R8", $sformatf("preset %02h:%02h:%02h", h, m, s), c, tod_ref(h, m, s));
    check("R8", "preset clears roll", {24'h0, r}, 0);
  endtask

  task automatic t_saturate();
    logic [7:0] r;
    @(negedge clk); s_tick = 1;
    repeat (4 * 300) @(negedge clk);
    s_tick = 0;
    @(negedge clk); s_rd = 1;
    @(negedge clk); s_rd = 0;
    check("R3", "roll saturated", {24'h0, s_roll}, 32'hFF);
    @(negedge clk); s_rd = 1;
    @(negedge clk); s_rd = 0;
    check("R5", "saturated roll cleared", {24'h0, s_roll}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_ticks();
    t_read_valid();
    t_wrap();
    t_read_with_wrap();
    t_load_priority();
    t_preset(8'h00, 8'h00, 8'h00, 1'b0);
    t_preset(8'h12, 8'h34, 8'h56, 1'b0);
    t_preset(8'h23, 8'h59, 8'h59, 1'b1);   // R9 nibble decode, R7 tick ignored
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule